// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Bank

This block is the software-visible register bank of a two-channel bus-master disk DMA controller. A 16-byte I/O window is split into two identical 8-byte banks, one per channel. Each bank holds a command register, a status register and a 32-bit descriptor-table pointer. Software reaches the banks through a simple request bus: valid, write enable, address, byte/word size and data. Read data and the error flag are returned combinationally in the same cycle.

Toward the DMA engine, each channel drives a one-cycle start pulse, an active level, a transfer-direction bit and the table pointer. The engine sends back per-channel completion and error events. The run state of each channel is held in a two-state machine. `CH_IDLE` moves to `CH_ACTIVE` on the "go" transition, which is a command write with the run bit set while the stored run bit is clear. `CH_ACTIVE` returns to `CH_IDLE` on one of three transitions: "halt" (a command write with the run bit clear), "finish" (a completion event) or "fault" (an error event). The status active bit is the state itself.

The status register combines three kinds of bit. Bits 6:5 are plain storage for software. Bit 0 is read-only to software. Bits 2:1 are write-one-to-clear flags that the engine sets.

Top module: `dma_port_regs`

## Requirements
- R1: Address bit 3 selects the channel (0 primary, 1 secondary) and bits 2:0 select the byte in its bank: command at 0x0, status at 0x2, table pointer at 0x4..0x7 with byte 0x4 holding pointer bits 7:0. A word access ignores address bit 0 and covers the even byte (data bits 7:0) and the next odd byte (data bits 15:8). The pointer is driven on `dma_tbl_ptr` (channel c on bits 32c+31:32c).
- R2: Table pointer bits 1:0 always read and drive as zero, whatever is written.
- R3: A byte write to status stores data bits 6:5 into status bits 6:5 and leaves status bit 0 (active) unchanged.
- R4: In a status byte write, a 1 in data bit 1 clears the error bit and a 1 in data bit 2 clears the interrupt bit. A 0 keeps the bit.
- R5: A word write that covers the status byte (offset 0x2 or 0x3) raises `bus_err` in that cycle and changes no register.
- R6: A command write with bit 0 set while the stored bit 0 is clear enters `CH_ACTIVE`. `dma_start` is then high for exactly the following cycle, and status bit 0 reads 1. Rewriting bit 0 as 1 while it is already stored as 1 gives no pulse.
- R7: A command write with bit 0 clear returns the channel to `CH_IDLE` and clears status bit 0, without setting the interrupt bit.
- R8: Command bit 3 is stored and driven on `dma_dir_rd` (1 means device-to-memory).
- R9: A completion event in `CH_ACTIVE` clears active and error and sets interrupt. Engine events in `CH_IDLE` are ignored.
- R10: An error event in `CH_ACTIVE` clears active and sets error and interrupt. It overrides a completion event in the same cycle.
- R11: When an engine event and a software clear of bits 2:1 hit the same cycle, the engine's setting wins.
- R12: Reset clears every register of both channels and all engine outputs.
- R13: Unused command and status bits and the bytes at offsets 0x1 and 0x3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 4 | Byte address in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (zero unless a read is valid) |
| bus_err | output | 1 | Rejected status write of wrong length |
| eng_done | input | 2 | Per-channel completion event |
| eng_err | input | 2 | Per-channel error event |
| dma_start | output | 2 | Per-channel one-cycle start pulse |
| dma_active | output | 2 | Per-channel active state |
| dma_dir_rd | output | 2 | Per-channel transfer direction |
| dma_tbl_ptr | output | 64 | Per-channel descriptor-table pointer |

## Verification
A software write to the status register and an engine event for the same channel can land in one clock edge. Their order then decides whether a flag survives. The bench drives a write-one-to-clear status write and an error or completion event in the same cycle. It then reads status back and expects the engine's setting to have won. It also puts a completion and an error event in one cycle and expects the error outcome, and it checks that engine events reaching an idle channel leave its status unchanged.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    typedef enum logic [0:0] {
        CH_IDLE   = 1'b0,
        CH_ACTIVE = 1'b1
    } ch_state_e;

    localparam int unsigned BANK_AW    = 3;
    localparam int unsigned BANK_BYTES = 1 << BANK_AW;
    localparam int unsigned PTR_W      = 32;
    localparam int unsigned PTR_BYTES  = PTR_W / 8;

    localparam logic [BANK_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [BANK_AW-1:0] OFS_STS  = 3'd2;
    localparam logic [BANK_AW-1:0] OFS_PTR  = 3'd4;

    localparam int unsigned CMD_RUN = 0;
    localparam int unsigned CMD_DIR = 3;
    localparam int unsigned STS_ACT = 0;
    localparam int unsigned STS_ERR = 1;
    localparam int unsigned STS_INT = 2;

    localparam logic [7:0] PTR_LOW_MASK = 8'hFC;

endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
    import dmr_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int CH_W   = ADDR_W - BANK_AW,
    localparam int NUM_CH = 1 << CH_W
) (
    input  logic                        bus_valid,
    input  logic                        bus_we,
    input  logic                        bus_word,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [15:0]                 bus_wdata,
    output logic [NUM_CH-1:0][BANK_BYTES-1:0] wr_be,
    output logic [BANK_BYTES-1:0][7:0]  wr_lane,
    output logic [CH_W-1:0]             rd_ch,
    output logic [BANK_AW-1:0]          rd_lo,
    output logic                        bad_len
);

    logic [BANK_AW-1:0] ofs_lo;
    logic [BANK_AW-1:0] ofs_hi;
    logic [CH_W-1:0]    ch_sel;
    logic               wr_ok;

    always_comb begin
        ofs_lo  = bus_word ? {bus_addr[BANK_AW-1:1], 1'b0} : bus_addr[BANK_AW-1:0];
        ofs_hi  = ofs_lo + 3'd1;
        ch_sel  = bus_addr[ADDR_W-1:BANK_AW];
        bad_len = bus_valid && bus_we && bus_word && (ofs_lo == OFS_STS);
        wr_ok   = bus_valid && bus_we && !bad_len;
        rd_ch   = ch_sel;
        rd_lo   = ofs_lo;
    end

    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_lane
        if (k % 2 == 1) begin : g_odd
            assign wr_lane[k] = bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
        end else begin : g_even
            assign wr_lane[k] = bus_wdata[7:0];
        end
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign wr_be[c][k] = wr_ok && (ch_sel == CH_W'(c)) &&
                                 ((ofs_lo == BANK_AW'(k)) ||
                                  (bus_word && (ofs_hi == BANK_AW'(k))));
        end
    end

endmodule

// File: rtl/dmr_channel.sv
module dmr_channel
    import dmr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BANK_BYTES-1:0]      wr_be,
    input  logic [BANK_BYTES-1:0][7:0] wr_lane,
    input  logic                       eng_done,
    input  logic                       eng_err,
    output logic [BANK_BYTES-1:0][7:0] rd_bytes,
    output logic                       start_o,
    output logic                       active_o,
    output logic                       dir_rd_o,
    output logic [PTR_W-1:0]           tbl_ptr_o
);

    ch_state_e        state_q, state_n;
    logic             run_q, dir_q;
    logic [1:0]       sw_q;
    logic             err_q, int_q;
    logic             start_q;
    logic [PTR_W-1:0] ptr_q;

    logic [7:0] cmd_wd, sts_wd;
    logic       cmd_we, sts_we;
    logic       go, halt;
    logic       err_n, int_n;
    logic [1:0] sw_n;
    logic       unused_lanes;

    assign cmd_we = wr_be[OFS_CMD];
    assign sts_we = wr_be[OFS_STS];
    assign cmd_wd = wr_lane[OFS_CMD];
    assign sts_wd = wr_lane[OFS_STS];
    assign go     = cmd_we && cmd_wd[CMD_RUN] && !run_q;
    assign halt   = cmd_we && !cmd_wd[CMD_RUN];

    assign unused_lanes = ^{wr_be[1], wr_be[3], wr_lane[1], wr_lane[3],
                            cmd_wd[7:4], cmd_wd[2:1], sts_wd[7], sts_wd[4:3], sts_wd[0]};

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CH_IDLE:   if (go) state_n = CH_ACTIVE;
            CH_ACTIVE: if (halt || eng_done || eng_err) state_n = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_n;
    end

    // status flag next values: software write first, engine setting wins
    always_comb begin
        sw_n  = sw_q;
        err_n = err_q;
        int_n = int_q;
        if (sts_we) begin
            sw_n  = sts_wd[6:5];
            err_n = err_q & ~sts_wd[STS_ERR];
            int_n = int_q & ~sts_wd[STS_INT];
        end
        if (state_q == CH_ACTIVE) begin
            if (eng_err) begin
                err_n = 1'b1;
                int_n = 1'b1;
            end else if (eng_done) begin
                err_n = 1'b0;
                int_n = 1'b1;
            end
        end
    end

    // output and register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            dir_q   <= 1'b0;
            sw_q    <= '0;
            err_q   <= 1'b0;
            int_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            if (cmd_we) begin
                run_q <= cmd_wd[CMD_RUN];
                dir_q <= cmd_wd[CMD_DIR];
            end
            sw_q    <= sw_n;
            err_q   <= err_n;
            int_q   <= int_n;
            start_q <= (state_q == CH_IDLE) && go;
        end
    end

    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
        localparam logic [7:0] MASK = (b == 0) ? PTR_LOW_MASK : 8'hFF;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   ptr_q[b*8 +: 8] <= '0;
            else if (wr_be[OFS_PTR + b])  ptr_q[b*8 +: 8] <= wr_lane[OFS_PTR + b] & MASK;
        end
        assign rd_bytes[OFS_PTR + b] = ptr_q[b*8 +: 8];
    end

    assign rd_bytes[0] = {4'b0, dir_q, 2'b0, run_q};
    assign rd_bytes[1] = 8'h00;
    assign rd_bytes[2] = {1'b0, sw_q, 2'b0, int_q, err_q, (state_q == CH_ACTIVE)};
    assign rd_bytes[3] = 8'h00;

    assign start_o   = start_q;
    assign active_o  = (state_q == CH_ACTIVE);
    assign dir_rd_o  = dir_q;
    assign tbl_ptr_o = ptr_q;

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q); // R6
    AST_START_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (state_q == CH_ACTIVE)); // R6
    AST_HALT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && halt) |=> (state_q == CH_IDLE)); // R7
    AST_FINISH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && eng_done && !eng_err) |=> (state_q == CH_IDLE && !err_q && int_q)); // R9
    AST_IDLE_EVENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !go && (eng_done || eng_err) && !sts_we) |=> $stable({err_q, int_q, state_q})); // R9
    AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && eng_err) |=> (state_q == CH_IDLE && err_q && int_q)); // R10
    AST_SW_BITS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        sts_we |=> (sw_q == $past(sts_wd[6:5]))); // R3
    AST_W1C_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && sts_wd[STS_ERR] && !(state_q == CH_ACTIVE && eng_err)) |=> !err_q); // R4

endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
    import dmr_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int CH_W   = ADDR_W - BANK_AW,
    localparam int NUM_CH = 1 << CH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_we,
    input  logic                    bus_word,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    output logic                    bus_err,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH-1:0]       eng_err,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_active,
    output logic [NUM_CH-1:0]       dma_dir_rd,
    output logic [NUM_CH*PTR_W-1:0] dma_tbl_ptr
);

    logic [NUM_CH-1:0][BANK_BYTES-1:0] wr_be;
    logic [BANK_BYTES-1:0][7:0]        wr_lane;
    logic [CH_W-1:0]                   rd_ch;
    logic [BANK_AW-1:0]                rd_lo;
    logic [BANK_AW-1:0]                rd_hi;
    logic                              bad_len;
    logic [BANK_BYTES-1:0][7:0]        ch_bytes [NUM_CH];
    logic [NUM_CH*8-1:0]               sts_flat;

    dmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_be     (wr_be),
        .wr_lane   (wr_lane),
        .rd_ch     (rd_ch),
        .rd_lo     (rd_lo),
        .bad_len   (bad_len)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dmr_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_be     (wr_be[c]),
            .wr_lane   (wr_lane),
            .eng_done  (eng_done[c]),
            .eng_err   (eng_err[c]),
            .rd_bytes  (ch_bytes[c]),
            .start_o   (dma_start[c]),
            .active_o  (dma_active[c]),
            .dir_rd_o  (dma_dir_rd[c]),
            .tbl_ptr_o (dma_tbl_ptr[c*PTR_W +: PTR_W])
        );
        assign sts_flat[c*8 +: 8] = ch_bytes[c][OFS_STS];
    end

    assign rd_hi   = rd_lo + 3'd1;
    assign bus_err = bad_len;

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_we) begin
            bus_rdata[7:0] = ch_bytes[rd_ch][rd_lo];
            if (bus_word) bus_rdata[15:8] = ch_bytes[rd_ch][rd_hi];
        end
    end

    AST_BAD_LEN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && eng_done == '0 && eng_err == '0) |=>
        ($stable(sts_flat) && $stable(dma_tbl_ptr) && $stable(dma_active) && $stable(dma_dir_rd))); // R5
    AST_ERR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_valid && bus_we && bus_word)); // R5

endmodule

// File: tb/dma_port_regs_tb_top.sv
module dma_port_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [1:0]  eng_done = '0, eng_err = '0;
    logic [1:0]  dma_start, dma_active, dma_dir_rd;
    logic [63:0] dma_tbl_ptr;

    int checks = 0;
    int errors = 0;
    logic [15:0] rd;
    logic        er;

    always #10 clk = ~clk;

    dma_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .eng_done(eng_done),
        .eng_err(eng_err), .dma_start(dma_start), .dma_active(dma_active),
        .dma_dir_rd(dma_dir_rd), .dma_tbl_ptr(dma_tbl_ptr)
    );

    typedef struct packed {
        logic        we;
        logic        word;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 4'h4, 16'h00AB, 16'h0000, 4'd1},  // R1 ptr byte 0
        '{1'b1, 1'b0, 4'h5, 16'h00CD, 16'h0000, 4'd1},  // R1 ptr byte 1
        '{1'b1, 1'b1, 4'h6, 16'h1234, 16'h0000, 4'd1},  // R1 ptr bytes 2,3
        '{1'b0, 1'b1, 4'h4, 16'h0000, 16'hCDA8, 4'd2},  // R2 low bits zero
        '{1'b0, 1'b1, 4'h6, 16'h0000, 16'h1234, 4'd1},  // R1 word lanes
        '{1'b0, 1'b1, 4'h5, 16'h0000, 16'hCDA8, 4'd1},  // R1 odd word aligned
        '{1'b1, 1'b0, 4'hC, 16'h0077, 16'h0000, 4'd1},  // R1 secondary ptr
        '{1'b0, 1'b0, 4'hC, 16'h0000, 16'h0074, 4'd2},  // R2 secondary
        '{1'b0, 1'b0, 4'h4, 16'h0000, 16'h00A8, 4'd1},  // R1 channel isolation
        '{1'b1, 1'b0, 4'h2, 16'h00FF, 16'h0000, 4'd3},  // R3 status write
        '{1'b0, 1'b0, 4'h2, 16'h0000, 16'h0060, 4'd3},  // R3 bits 6:5 only
        '{1'b0, 1'b0, 4'hA, 16'h0000, 16'h0000, 4'd1},  // R1 other status
        '{1'b1, 1'b0, 4'h0, 16'h00FE, 16'h0000, 4'd8},  // R8 dir bit
        '{1'b0, 1'b0, 4'h0, 16'h0000, 16'h0008, 4'd13}, // R13 cmd unused
        '{1'b0, 1'b0, 4'h1, 16'h0000, 16'h0000, 4'd13}, // R13 offset 1
        '{1'b0, 1'b1, 4'h2, 16'h0000, 16'h0060, 4'd13}, // R13 offset 3
        '{1'b1, 1'b0, 4'h2, 16'h0000, 16'h0000, 4'd3},  // R3 clear sw bits
        '{1'b0, 1'b0, 4'h2, 16'h0000, 16'h0000, 4'd3},  // R3
        '{1'b0, 1'b0, 4'h8, 16'h0000, 16'h0000, 4'd1}   // R1 secondary cmd
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic word, input logic [3:0] a,
                          input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = d;
        #5;
        rd = bus_rdata;
        er = bus_err;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_we = 1'b0; bus_word = 1'b0;
    endtask

    task automatic rd_byte(input logic [3:0] a);
        bus_op(1'b0, 1'b0, a, 16'h0);
    endtask

    task automatic eng_op(input logic [1:0] dn, input logic [1:0] ee);
        @(negedge clk);
        eng_done = dn; eng_err = ee;
        @(posedge clk);
        #1;
        eng_done = '0; eng_err = '0;
    endtask

    task automatic both_op(input logic [3:0] a, input logic [15:0] d,
                           input logic [1:0] dn, input logic [1:0] ee);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_word = 1'b0; bus_addr = a; bus_wdata = d;
        eng_done = dn; eng_err = ee;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_we = 1'b0;
        eng_done = '0; eng_err = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 active", {62'b0, dma_active}, 64'h0);
        check("R12 ptr", dma_tbl_ptr, 64'h0);
        rst_n = 1'b1;
        rd_byte(4'h2);
        check("R12 status", {48'b0, rd}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].we, VEC[i].word, VEC[i].addr, VEC[i].data);
            if (!VEC[i].we)
                check($sformatf("R%0d vec %0d", VEC[i].req, i), {48'b0, rd}, {48'b0, VEC[i].exp});
        end
        check("R1 ptr ports", dma_tbl_ptr, 64'h00000074_1234CDA8);
        check("R8 dir", {62'b0, dma_dir_rd}, 64'h1);

        // R5 wrong-length status write
        bus_op(1'b1, 1'b0, 4'h2, 16'h0020);
        check("R5 byte ok", {63'b0, er}, 64'h0);
        bus_op(1'b1, 1'b1, 4'h2, 16'h0040);
        check("R5 err", {63'b0, er}, 64'h1);
        bus_op(1'b1, 1'b1, 4'h3, 16'hFFFF);
        check("R5 err odd", {63'b0, er}, 64'h1);
        rd_byte(4'h2);
        check("R5 unchanged", {48'b0, rd}, 64'h20);

        // R6 start
        bus_op(1'b1, 1'b0, 4'h0, 16'h0009);
        check("R6 pulse", {62'b0, dma_start}, 64'h1);
        check("R6 active", {62'b0, dma_active}, 64'h1);
        @(posedge clk); #1;
        check("R6 one cycle", {62'b0, dma_start}, 64'h0);
        rd_byte(4'h2);
        check("R6 status", {48'b0, rd}, 64'h21);
        bus_op(1'b1, 1'b0, 4'h2, 16'h0000);
        rd_byte(4'h2);
        check("R3 bit0 read-only", {48'b0, rd}, 64'h01);
        bus_op(1'b1, 1'b0, 4'h0, 16'h0009);
        check("R6 no re-pulse", {62'b0, dma_start}, 64'h0);

        // R9 completion, then ignored events in idle
        eng_op(2'b01, 2'b00);
        check("R9 inactive", {62'b0, dma_active}, 64'h0);
        rd_byte(4'h2);
        check("R9 status", {48'b0, rd}, 64'h04);
        eng_op(2'b01, 2'b01);
        rd_byte(4'h2);
        check("R9 idle ignored", {48'b0, rd}, 64'h04);

        // R4 write-one-to-clear
        bus_op(1'b1, 1'b0, 4'h2, 16'h0000);
        rd_byte(4'h2);
        check("R4 zero keeps", {48'b0, rd}, 64'h04);
        bus_op(1'b1, 1'b0, 4'h2, 16'h0004);
        rd_byte(4'h2);
        check("R4 one clears", {48'b0, rd}, 64'h00);

        // R7 halt
        bus_op(1'b1, 1'b0, 4'h0, 16'h0008);
        bus_op(1'b1, 1'b0, 4'h0, 16'h0009);
        check("R6 restart", {62'b0, dma_start}, 64'h1);
        bus_op(1'b1, 1'b0, 4'h0, 16'h0008);
        check("R7 inactive", {62'b0, dma_active}, 64'h0);
        rd_byte(4'h2);
        check("R7 status", {48'b0, rd}, 64'h00);

        // R10 error beats completion, secondary channel
        bus_op(1'b1, 1'b0, 4'h8, 16'h0001);
        check("R6 secondary", {62'b0, dma_start}, 64'h2);
        eng_op(2'b10, 2'b10);
        check("R10 inactive", {62'b0, dma_active}, 64'h0);
        rd_byte(4'hA);
        check("R10 status", {48'b0, rd}, 64'h06);

        // R11 engine set beats same-cycle clear
        bus_op(1'b1, 1'b0, 4'hA, 16'h0006);
        rd_byte(4'hA);
        check("R4 both clear", {48'b0, rd}, 64'h00);
        bus_op(1'b1, 1'b0, 4'h8, 16'h0000);
        bus_op(1'b1, 1'b0, 4'h8, 16'h0001);
        both_op(4'hA, 16'h0006, 2'b00, 2'b10);
        rd_byte(4'hA);
        check("R11 err wins", {48'b0, rd}, 64'h06);
        bus_op(1'b1, 1'b0, 4'h0, 16'h0009);
        both_op(4'h2, 16'h0004, 2'b01, 2'b00);
        rd_byte(4'h2);
        check("R11 done wins", {48'b0, rd}, 64'h04);

        // R12 reset while running
        bus_op(1'b1, 1'b0, 4'h0, 16'h0008);
        bus_op(1'b1, 1'b0, 4'h0, 16'h0009);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R12 run reset", {56'b0, dma_active, dma_dir_rd, dma_start}, 64'h0);
        check("R12 ptr reset", dma_tbl_ptr, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_op(1'b0, 1'b1, 4'h0, 16'h0);
        check("R12 cmd", {48'b0, rd}, 64'h0);
        bus_op(1'b0, 1'b1, 4'h4, 16'h0);
        check("R12 ptr read", {48'b0, rd}, 64'h0);

        summary();
    end

endmodule